// File: doc/BRIEF.md
# Programmable Logic Gate Neuron Layer

This block is one layer of a binary logic network. It holds a row of neurons. Each neuron picks two bits, a and b, from the layer input vector and produces one output bit. A per-neuron 4-bit gate code chooses which of the sixteen two-input Boolean functions the neuron applies. Two index registers per neuron choose which input bits become a and b. All gate codes and indices are loaded at run time through a single-cycle write port that addresses one neuron at a time.

The `OUT_REG` parameter sets how the output leaves the layer. With `OUT_REG = 0` the output is pure logic and follows the input within the same cycle. With `OUT_REG = 1` a register sits on the output. A deep network is built by chaining instances. Registered and unregistered layers are mixed along the chain to set the latency and the clock rate.

Top module: `gate_layer`

## Requirements
- R1: Codes 0 to 7 select, in order, the following functions: constant 0, a AND b, a AND NOT b, a, NOT a AND b, b, a XOR b, a OR b. Over all sixteen codes the output equals bit number 3 − (2·a + b) of the code.
- R2: Codes 8 to 15 select, in order, the following functions: NOR, XNOR, NOT b, a OR NOT b, NOT a, NOT a OR b, NAND, constant 1. The same bit rule as in R1 holds.
- R3: Neuron n reads a from input bit `idxA[n]` and b from input bit `idxB[n]`. An index of `IN_W` or more reads as 0.
- R4: Reset clears every gate code and index to 0. Code 0 is constant 0, so `layerOut` is all zeros after reset, whatever the input.
- R5: With `OUT_REG = 0` the output follows `layerIn` in the same cycle, with no clock edge needed. Output bit n belongs to neuron n.
- R6: With `OUT_REG = 1` the output is captured on the rising clock edge, so it lags the input by one cycle. An active-high synchronous reset clears it to zero at the edge and not before.
- R7: A write presented at a clock edge is used by every evaluation after that edge. An unregistered layer shows the new function right after the edge. A registered layer shows it one edge later.
- R8: A write changes only the addressed neuron. A write to a neuron number of `NEURONS` or more changes nothing.
- R9: When `rst` and `cfgWe` are both high at the same edge, the reset wins and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cfgWe | input | 1 | Configuration write strobe |
| cfgNeuron | input | NSEL_W | Neuron number addressed by the write |
| cfgGate | input | 4 | Gate code to store |
| cfgIdxA | input | IDX_W | Input bit index for operand a |
| cfgIdxB | input | IDX_W | Input bit index for operand b |
| layerIn | input | IN_W | Layer input vector |
| layerOut | output | NEURONS | One result bit per neuron |

## Verification
Two events can land on the same edge: a configuration write and an evaluation that has to choose between the old function and the new one. A reset and a write can also land on the same edge. The bench holds the input steady across a write and compares both the unregistered and the registered instance on the next half cycle. The unregistered instance must already show the new function. The registered instance must still hold the value built from the old function. A further case drives reset and a constant-one write at the same edge, then checks that every output stays zero after reset is released.

// File: rtl/gate_layer_pkg.sv
package gate_layer_pkg;

  typedef enum logic [3:0] {
    G_ZERO    = 4'd0,
    G_AND     = 4'd1,
    G_A_NB    = 4'd2,
    G_PASS_A  = 4'd3,
    G_NA_B    = 4'd4,
    G_PASS_B  = 4'd5,
    G_XOR     = 4'd6,
    G_OR      = 4'd7,
    G_NOR     = 4'd8,
    G_XNOR    = 4'd9,
    G_NOT_B   = 4'd10,
    G_A_OR_NB = 4'd11,
    G_NOT_A   = 4'd12,
    G_NA_OR_B = 4'd13,
    G_NAND    = 4'd14,
    G_ONE     = 4'd15
  } gateOp_e;

  // strobe bundle from control to datapath
  typedef struct packed {
    logic       load;
    logic [3:0] gate;
  } cfgStrobe_t;

  function automatic logic evalGate(input logic [3:0] code, input logic a, input logic b);
    logic r;
    case (gateOp_e'(code))
      G_ZERO:    r = 1'b0;
      G_AND:     r = a & b;
      G_A_NB:    r = a & ~b;
      G_PASS_A:  r = a;
      G_NA_B:    r = ~a & b;
      G_PASS_B:  r = b;
      G_XOR:     r = a ^ b;
      G_OR:      r = a | b;
      G_NOR:     r = ~(a | b);
      G_XNOR:    r = ~(a ^ b);
      G_NOT_B:   r = ~b;
      G_A_OR_NB: r = a | ~b;
      G_NOT_A:   r = ~a;
      G_NA_OR_B: r = ~a | b;
      G_NAND:    r = ~(a & b);
      default:   r = 1'b1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/gate_layer_ctrl.sv
module gate_layer_ctrl
  import gate_layer_pkg::*;
#(
  parameter int NEURONS = 6,
  parameter int NSEL_W  = 3
) (
  input  logic               rst,
  input  logic               cfgWe,
  input  logic [NSEL_W-1:0]  cfgNeuron,
  input  logic [3:0]         cfgGate,
  output cfgStrobe_t         strobe,
  output logic [NEURONS-1:0] loadSel
);

  logic inRange;

  assign inRange      = int'(cfgNeuron) < NEURONS;
  assign strobe.load  = cfgWe && !rst && inRange;
  assign strobe.gate  = cfgGate;

  for (genvar n = 0; n < NEURONS; n++) begin : g_sel
    assign loadSel[n] = (cfgNeuron == NSEL_W'(n));
  end

endmodule

// File: rtl/gate_layer_dpath.sv
module gate_layer_dpath
  import gate_layer_pkg::*;
#(
  parameter int IN_W    = 8,
  parameter int NEURONS = 6,
  parameter int IDX_W   = 4,
  parameter bit OUT_REG = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  cfgStrobe_t         strobe,
  input  logic [NEURONS-1:0] loadSel,
  input  logic [IDX_W-1:0]   idxA,
  input  logic [IDX_W-1:0]   idxB,
  input  logic [IN_W-1:0]    layerIn,
  output logic [NEURONS-1:0] layerOut
);

  localparam int PAD_W = 1 << IDX_W;

  logic [PAD_W-1:0]   padIn;
  logic [NEURONS-1:0] evalOut;

  // indices past the input width land on zero padding
  assign padIn = {{(PAD_W-IN_W){1'b0}}, layerIn};

  for (genvar n = 0; n < NEURONS; n++) begin : g_neuron
    logic [3:0]       gateQ;
    logic [IDX_W-1:0] selAQ;
    logic [IDX_W-1:0] selBQ;

    always_ff @(posedge clk) begin
      if (rst) begin
        gateQ <= '0;
        selAQ <= '0;
        selBQ <= '0;
      end else if (strobe.load && loadSel[n]) begin
        gateQ <= strobe.gate;
        selAQ <= idxA;
        selBQ <= idxB;
      end
    end

    assign evalOut[n] = evalGate(gateQ, padIn[selAQ], padIn[selBQ]);
  end

  if (OUT_REG) begin : g_reg
    logic [NEURONS-1:0] outQ;
    always_ff @(posedge clk) begin
      if (rst) outQ <= '0;
      else     outQ <= evalOut;
    end
    assign layerOut = outQ;
  end else begin : g_comb
    assign layerOut = evalOut;
  end

endmodule

// File: rtl/gate_layer.sv
module gate_layer
  import gate_layer_pkg::*;
#(
  parameter int  IN_W    = 8,
  parameter int  NEURONS = 6,
  parameter bit  OUT_REG = 1'b1,
  localparam int IDX_W   = $clog2(IN_W) + 1,
  localparam int NSEL_W  = (NEURONS > 1) ? $clog2(NEURONS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfgWe,
  input  logic [NSEL_W-1:0]  cfgNeuron,
  input  logic [3:0]         cfgGate,
  input  logic [IDX_W-1:0]   cfgIdxA,
  input  logic [IDX_W-1:0]   cfgIdxB,
  input  logic [IN_W-1:0]    layerIn,
  output logic [NEURONS-1:0] layerOut
);

  cfgStrobe_t         strobe;
  logic [NEURONS-1:0] loadSel;

  gate_layer_ctrl #(
    .NEURONS(NEURONS),
    .NSEL_W (NSEL_W)
  ) ctrl_i (
    .rst      (rst),
    .cfgWe    (cfgWe),
    .cfgNeuron(cfgNeuron),
    .cfgGate  (cfgGate),
    .strobe   (strobe),
    .loadSel  (loadSel)
  );

  gate_layer_dpath #(
    .IN_W   (IN_W),
    .NEURONS(NEURONS),
    .IDX_W  (IDX_W),
    .OUT_REG(OUT_REG)
  ) dpath_i (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .loadSel (loadSel),
    .idxA    (cfgIdxA),
    .idxB    (cfgIdxB),
    .layerIn (layerIn),
    .layerOut(layerOut)
  );

endmodule

// File: rtl/gate_layer_chk.sv
module gate_layer_chk #(
  parameter int IN_W    = 8,
  parameter int NEURONS = 6,
  parameter int NSEL_W  = 3,
  parameter bit OUT_REG = 1'b1
) (
  input logic               clk,
  input logic               rst,
  input logic               cfgWe,
  input logic [NSEL_W-1:0]  cfgNeuron,
  input logic [IN_W-1:0]    layerIn,
  input logic [NEURONS-1:0] layerOut
);

  // R4
  reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> layerOut == '0);

  // R9
  reset_beats_write_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst && cfgWe) |-> layerOut == '0);

  if (OUT_REG) begin : g_reg
    // R6
    reg_holds_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(rst, 2) && !$past(cfgWe, 2) &&
       $past(layerIn) == $past(layerIn, 2)) |-> $stable(layerOut));

    // R8
    stray_write_reg_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(rst, 2) &&
       $past(cfgWe && (int'(cfgNeuron) >= NEURONS), 2) &&
       $past(layerIn) == $past(layerIn, 2)) |-> $stable(layerOut));
  end else begin : g_comb
    // R5
    comb_follows_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(cfgWe) && $stable(layerIn)) |-> $stable(layerOut));

    // R8
    stray_write_comb_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(cfgWe && (int'(cfgNeuron) >= NEURONS)) &&
       $stable(layerIn)) |-> $stable(layerOut));
  end

endmodule

bind gate_layer gate_layer_chk #(
  .IN_W   (IN_W),
  .NEURONS(NEURONS),
  .NSEL_W (NSEL_W),
  .OUT_REG(OUT_REG)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .cfgWe    (cfgWe),
  .cfgNeuron(cfgNeuron),
  .layerIn  (layerIn),
  .layerOut (layerOut)
);

// File: tb/gate_layer_tb_top.sv
module gate_layer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int IN_W    = 8;
  localparam int NEURONS = 6;
  localparam int IDX_W   = 4;
  localparam int NSEL_W  = 3;
  localparam int NVEC    = 16;

  // entry: {neuron[3:0], code[3:0], idxA[3:0], idxB[3:0], input[7:0]}
  localparam logic [23:0] VEC [NVEC] = '{
    24'h010103, 24'h162784, 24'h274500, 24'h386640,
    24'h4E31FF, 24'h597081, 24'h050CFF, 24'h1C90FF,
    24'h2BF8AA, 24'h325220, 24'h441640, 24'h5D230C,
    24'h037F80, 24'h1AE410, 24'h2F0000, 24'h3011FF
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfgWe = 1'b0;
  logic [NSEL_W-1:0] cfgNeuron = '0;
  logic [3:0] cfgGate = '0;
  logic [IDX_W-1:0] cfgIdxA = '0;
  logic [IDX_W-1:0] cfgIdxB = '0;
  logic [IN_W-1:0] layerIn = '0;
  logic [NEURONS-1:0] regOut;
  logic [NEURONS-1:0] combOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [3:0]       mGate [NEURONS];
  logic [IDX_W-1:0] mA    [NEURONS];
  logic [IDX_W-1:0] mB    [NEURONS];

  always #(CLK_PERIOD/2) clk = ~clk;

  gate_layer #(.IN_W(IN_W), .NEURONS(NEURONS), .OUT_REG(1'b1)) dut_i (
    .clk(clk), .rst(rst), .cfgWe(cfgWe), .cfgNeuron(cfgNeuron), .cfgGate(cfgGate),
    .cfgIdxA(cfgIdxA), .cfgIdxB(cfgIdxB), .layerIn(layerIn), .layerOut(regOut)
  );

  gate_layer #(.IN_W(IN_W), .NEURONS(NEURONS), .OUT_REG(1'b0)) comb_i (
    .clk(clk), .rst(rst), .cfgWe(cfgWe), .cfgNeuron(cfgNeuron), .cfgGate(cfgGate),
    .cfgIdxA(cfgIdxA), .cfgIdxB(cfgIdxB), .layerIn(layerIn), .layerOut(combOut)
  );

  function automatic logic pickBit(input logic [IN_W-1:0] v, input logic [IDX_W-1:0] idx);
    return (int'(idx) < IN_W) ? v[idx] : 1'b0;
  endfunction

  // truth-table rule of R1/R2: bit 3-(2a+b) of the code
  function automatic logic [NEURONS-1:0] expOut(input logic [IN_W-1:0] v);
    logic [NEURONS-1:0] e;
    for (int n = 0; n < NEURONS; n++) begin
      int a = int'(pickBit(v, mA[n]));
      int b = int'(pickBit(v, mB[n]));
      e[n] = mGate[n][3 - (2*a + b)];
    end
    return e;
  endfunction

  task automatic modelReset();
    for (int n = 0; n < NEURONS; n++) begin
      mGate[n] = '0; mA[n] = '0; mB[n] = '0;
    end
  endtask

  task automatic check(input string tag, input logic [NEURONS-1:0] act, input logic [NEURONS-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  // called at a negedge; returns at the negedge after the write edge
  task automatic writeCfg(input int n, input logic [3:0] g, input logic [IDX_W-1:0] a, input logic [IDX_W-1:0] b);
    cfgWe = 1'b1; cfgNeuron = NSEL_W'(n); cfgGate = g; cfgIdxA = a; cfgIdxB = b;
    @(posedge clk);
    @(negedge clk);
    cfgWe = 1'b0;
    if (n < NEURONS && !rst) begin
      mGate[n] = g; mA[n] = a; mB[n] = b;
    end
  endtask

  task automatic applyAndCheck(input logic [IN_W-1:0] v, input string tag);
    layerIn = v;
    #1;
    check({tag, " comb"}, combOut, expOut(v));
    @(posedge clk);
    @(negedge clk);
    check({tag, " reg"}, regOut, expOut(v));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [NEURONS-1:0] oldExp;
    modelReset();
    layerIn = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R4: reset state with all-ones input
    check("R4 reset comb", combOut, '0);
    check("R4 reset reg", regOut, '0);

    // R1 / R2: every code, every operand pair, on neuron 2 (a=bit3, b=bit5)
    for (int c = 0; c < 16; c++) begin
      writeCfg(2, 4'(c), 4'd3, 4'd5);
      for (int ab = 0; ab < 4; ab++) begin
        logic [IN_W-1:0] v;
        v = '0;
        v[3] = ab[1];
        v[5] = ab[0];
        applyAndCheck(v, (c < 8) ? "R1" : "R2");
      end
    end

    // R3: table of selections, including out-of-range indices
    for (int i = 0; i < NVEC; i++) begin
      logic [23:0] e;
      e = VEC[i];
      writeCfg(int'(e[23:20]), e[19:16], e[15:12], e[11:8]);
      applyAndCheck(e[7:0], "R3");
    end

    // R4 / R9: reset together with a write of constant one
    rst = 1'b1;
    cfgWe = 1'b1; cfgNeuron = '0; cfgGate = 4'hF; cfgIdxA = '0; cfgIdxB = '0;
    @(posedge clk);
    @(negedge clk);
    cfgWe = 1'b0;
    rst = 1'b0;
    modelReset();
    layerIn = 8'h5A;
    #1;
    check("R9 comb", combOut, '0);
    @(posedge clk);
    @(negedge clk);
    check("R9 reg", regOut, '0);
    check("R4 comb after reset", combOut, '0);

    // R8: stray writes to neuron numbers 6 and 7
    writeCfg(6, 4'hF, 4'd0, 4'd0);
    writeCfg(7, 4'hF, 4'd0, 4'd0);
    applyAndCheck(8'hFF, "R8 stray");
    // R8: write one neuron, only its bit moves
    writeCfg(1, 4'hF, 4'd0, 4'd0);
    applyAndCheck(8'h00, "R8 single");
    check("R8 only bit1", combOut, 6'b000010);

    // R5: output follows input with no clock edge
    writeCfg(0, 4'd3, 4'd4, 4'd0);
    applyAndCheck(8'h00, "R5 base");
    oldExp = expOut(8'h00);
    layerIn = 8'h10;
    #1;
    check("R5 comb same cycle", combOut, expOut(8'h10));
    check("R6 reg waits edge", regOut, oldExp);
    @(posedge clk);
    @(negedge clk);
    check("R6 reg after edge", regOut, expOut(8'h10));

    // R7: write timing, input held steady
    oldExp = expOut(8'h10);
    writeCfg(0, 4'd12, 4'd4, 4'd0);
    #1;
    check("R7 comb new function", combOut, expOut(8'h10));
    check("R7 reg old function", regOut, oldExp);
    @(posedge clk);
    @(negedge clk);
    check("R7 reg new function", regOut, expOut(8'h10));

    // R6: synchronous reset of the output register
    writeCfg(3, 4'hF, 4'd0, 4'd0);
    applyAndCheck(8'h10, "R6 nonzero");
    rst = 1'b1;
    #1;
    check("R6 no async clear", regOut, expOut(8'h10));
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    modelReset();
    #1;
    check("R6 sync clear reg", regOut, '0);
    check("R4 sync clear comb", combOut, '0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule